// File: doc/BRIEF.md
# Audio ADC DC Offset Removal Filter

This block removes the slowly varying DC component from two channels of signed 24-bit audio that leave an ADC decimation filter. For each channel it keeps a running estimate of the offset in a leaky integrator with a time constant of 2^SHIFT samples. It subtracts the estimate, as it stood before the current sample, from every sample that arrives with the valid strobe.

Each channel runs in one of three modes, picked by its own enable and freeze bits. In tracking mode the estimate follows the input and is subtracted. In hold mode the estimate is held at its learned value and is still subtracted. In bypass mode the sample passes through unchanged and the estimate is cleared, so a later re-enable starts learning from zero. The difference saturates to the signed 24-bit range, and a flag marks every output word in which either channel clipped.

Top module: `dc_trim_filter`

## Requirements
- R1: Synchronous active-high reset clears both estimates, `out_valid`, `clip_flag` and both output samples to zero. The first enabled sample after reset therefore comes out equal to its input.
- R2: Each `in_valid` cycle produces exactly one `out_valid` cycle one clock later. Without `in_valid` no output is produced and the estimates do not change, whatever the sample inputs carry.
- R3: In tracking mode (enable=1, freeze=0) the output is x − floor(acc / 2^12), where acc is the channel's 36-bit estimate held before this sample.
- R4: In tracking mode the estimate updates as acc ← acc + floor(((x·2^12) − acc) / 2^12), using signed arithmetic.
- R5: The two channels keep separate estimates, enables and freezes. Index 0 is the left channel and index 1 is the right channel. Stimulus or mode on one channel never changes the other channel's output.
- R6: In hold mode (enable=1, freeze=1) the estimate is held and is still subtracted from every sample, so a constant input gives a constant output.
- R7: With enable=0 the output equals the input regardless of freeze, and the estimate is cleared to zero.
- R8: A difference above 8388607 is output as 8388607, and one below −8388608 is output as −8388608. `clip_flag` is high in exactly the output cycle in which either channel saturated.
- R9: `clip_flag` stays low for every output in which neither channel saturated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left sample, signed two's complement |
| in_right | input | 24 | Right sample, signed two's complement |
| hp_enable | input | 2 | Per-channel filter enable, bit 0 left, bit 1 right |
| hp_freeze | input | 2 | Per-channel estimate hold, bit 0 left, bit 1 right |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_left | output | 24 | Corrected left sample |
| out_right | output | 24 | Corrected right sample |
| clip_flag | output | 1 | High when either channel saturated in this output |

## Verification
Saturation is the hardest case to reach from the ports. A difference outside the 24-bit range needs an estimate close to one rail while the input sits at the other rail, and the estimate only gets near a rail after several time constants at full scale. The stimulus drives each channel at an opposite rail for 20000 consecutive strobes. It then freezes both estimates and applies the opposite extreme, so the clipping is repeatable. Finally it applies small values under the same frozen estimates, to show the flag drops again. A bit-exact model in the bench follows the integrator through every step of this sequence.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_TRACK  = 2'd1,
    MODE_HOLD   = 2'd2
  } dcf_mode_e;

  function automatic dcf_mode_e mode_of(input logic en, input logic frz);
    if (!en)      return MODE_BYPASS;
    else if (frz) return MODE_HOLD;
    else          return MODE_TRACK;
  endfunction

endpackage

// File: rtl/dcf_offset_est.sv
module dcf_offset_est
  import dcf_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  dcf_mode_e                mode,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] est
);
  localparam int ACC_W = DATA_W + SHIFT;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W:0]   x_scaled;
  logic signed [ACC_W:0]   acc_ext;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;

  assign x_scaled = {x[DATA_W-1], x, {SHIFT{1'b0}}};
  assign acc_ext  = {acc[ACC_W-1], acc};
  assign diff     = x_scaled - acc_ext;
  assign step     = diff >>> SHIFT;
  assign est      = acc[ACC_W-1:SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (smp_valid) begin
      case (mode)
        MODE_BYPASS: acc <= '0;
        MODE_TRACK:  acc <= acc + step[ACC_W-1:0];
        default:     acc <= acc;
      endcase
    end
  end

  p_clear_on_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mode == MODE_BYPASS) |=> (acc == '0));

  p_hold_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mode == MODE_HOLD) |=> $stable(acc));

  p_idle_keeps_acc_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(acc));

endmodule

// File: rtl/dcf_sat_sub.sv
module dcf_sat_sub #(
  parameter int DATA_W = 24
) (
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [DATA_W-1:0] y,
  output logic                     clipped
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] d;

  assign d = {a[DATA_W-1], a} - {b[DATA_W-1], b};

  always_comb begin
    clipped = (d[DATA_W] != d[DATA_W-1]);
    if (!clipped)        y = d[DATA_W-1:0];
    else if (d[DATA_W])  y = MIN_V;
    else                 y = MAX_V;
  end

  a_no_wrap_r8: assert final (clipped || (d[DATA_W-1:0] == y));

endmodule

// File: rtl/dcf_channel.sv
module dcf_channel
  import dcf_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic                     en,
  input  logic                     frz,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y,
  output logic                     clip
);
  dcf_mode_e               mode;
  logic signed [DATA_W-1:0] est;
  logic signed [DATA_W-1:0] sub_y;
  logic                     sub_clip;

  assign mode = mode_of(en, frz);

  dcf_offset_est #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_est (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .mode      (mode),
    .x         (x),
    .est       (est)
  );

  dcf_sat_sub #(.DATA_W(DATA_W)) u_sub (
    .a       (x),
    .b       (est),
    .y       (sub_y),
    .clipped (sub_clip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y    <= '0;
      clip <= 1'b0;
    end else if (smp_valid) begin
      if (mode == MODE_BYPASS) begin
        y    <= x;
        clip <= 1'b0;
      end else begin
        y    <= sub_y;
        clip <= sub_clip;
      end
    end else begin
      clip <= 1'b0;
    end
  end

  p_bypass_passthru_r7: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !en) |=> (y == $past(x) && !clip));

endmodule

// File: rtl/dc_trim_filter.sv
module dc_trim_filter #(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [1:0]        hp_enable,
  input  logic [1:0]        hp_freeze,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              clip_flag
);
  localparam int NCH = 2;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] ch_x [NCH];
  logic signed [DATA_W-1:0] ch_y [NCH];
  logic [NCH-1:0]           ch_clip;

  assign ch_x[0] = in_left;
  assign ch_x[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcf_channel #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (in_valid),
      .en        (hp_enable[c]),
      .frz       (hp_freeze[c]),
      .x         (ch_x[c]),
      .y         (ch_y[c]),
      .clip      (ch_clip[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign out_left  = ch_y[0];
  assign out_right = ch_y[1];
  assign clip_flag = |ch_clip;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !clip_flag && out_left == '0 && out_right == '0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_clip_at_rail_r8: assert property (@(posedge clk) disable iff (rst)
    clip_flag |-> (out_left == MAX_V || out_left == MIN_V ||
                   out_right == MAX_V || out_right == MIN_V));

  p_clip_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    clip_flag |-> out_valid);

endmodule

// File: tb/dc_trim_filter_tb.sv
module dc_trim_filter_tb;
  localparam int DW = 24;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic [1:0]    hp_enable = 2'b00;
  logic [1:0]    hp_freeze = 2'b00;
  logic          out_valid;
  logic [DW-1:0] out_left;
  logic [DW-1:0] out_right;
  logic          clip_flag;

  always #4 clk = ~clk;

  dc_trim_filter #(.DATA_W(DW), .SHIFT(12)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .hp_enable(hp_enable), .hp_freeze(hp_freeze),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .clip_flag(clip_flag)
  );

  typedef struct {
    logic [DW-1:0] l;
    logic [DW-1:0] r;
    logic          c;
    string         tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     errors = 0;
  longint acc [2];
  string  cur_tag = "R3";

  function automatic void model(input int ch, input logic [DW-1:0] xin,
                                input logic en, input logic frz,
                                output logic [DW-1:0] y, output logic c);
    longint x, d;
    x = longint'($signed(xin));
    c = 1'b0;
    if (!en) begin
      y = xin;
      acc[ch] = 0;
    end else begin
      d = x - (acc[ch] >>> 12);
      if (d > MAXV) begin d = MAXV; c = 1'b1; end
      else if (d < MINV) begin d = MINV; c = 1'b1; end
      y = d[DW-1:0];
      if (!frz) acc[ch] = acc[ch] + (((x <<< 12) - acc[ch]) >>> 12);
    end
  endfunction

  task automatic drive(input logic [DW-1:0] l, input logic [DW-1:0] r,
                       input logic [1:0] en, input logic [1:0] frz);
    exp_t e;
    logic cl, cr;
    @(negedge clk);
    in_valid  = 1'b1;
    in_left   = l;
    in_right  = r;
    hp_enable = en;
    hp_freeze = frz;
    model(0, l, en[0], frz[0], e.l, cl);
    model(1, r, en[1], frz[1], e.r, cr);
    e.c   = cl | cr;
    e.tag = cur_tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_left  = DW'(24'h5A5A5A + i);
      in_right = DW'(24'hA5A5A5 - i);
      hp_enable = 2'b11;
      hp_freeze = 2'b00;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R2: out_valid with nothing expected (actual 1, expected 0)");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (out_left !== e.l || out_right !== e.r || clip_flag !== e.c) begin
            errors++;
            $display("FAIL %s: actual L=%0d R=%0d clip=%0b, expected L=%0d R=%0d clip=%0b",
                     e.tag, $signed(out_left), $signed(out_right), clip_flag,
                     $signed(e.l), $signed(e.r), e.c);
          end
        end
      end
    end
  end

  task automatic check_flag(input string tag, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp_v);
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    acc[0] = 0;
    acc[1] = 0;
    repeat (5) @(negedge clk);
    // R1: reset state at the ports
    check_flag("R1 out_valid", out_valid, 1'b0);
    check_flag("R1 clip_flag", clip_flag, 1'b0);
    check_flag("R1 outputs zero", (out_left == '0 && out_right == '0), 1'b1);
    rst = 1'b0;

    // R1/R3: first enabled samples start from a zero estimate
    cur_tag = "R1";
    drive(DW'(1000), DW'(-5000), 2'b11, 2'b00);
    // R3/R4: tracking of a constant offset
    cur_tag = "R3";
    for (int i = 0; i < 200; i++) drive(DW'(1000), DW'(-5000), 2'b11, 2'b00);
    // R4: varied pattern
    cur_tag = "R4";
    for (int i = 0; i < 300; i++)
      drive(DW'(2000 + (i % 7) * 31337 - 100000), DW'(-(i * 977) + 40000), 2'b11, 2'b00);

    // R2: gaps with changing inputs must not move the estimate or emit output
    cur_tag = "R2";
    idle(6);
    @(negedge clk);
    check_flag("R2 no output while idle", out_valid, 1'b0);
    drive(DW'(3333), DW'(-3333), 2'b11, 2'b00);
    idle(3);
    drive(DW'(3333), DW'(-3333), 2'b11, 2'b00);

    // R6/R5: freeze left only, constant input gives constant output
    cur_tag = "R6";
    for (int i = 0; i < 100; i++) drive(DW'(50000), DW'(-7000), 2'b11, 2'b01);
    // R5: right tracks while left held
    cur_tag = "R5";
    for (int i = 0; i < 100; i++) drive(DW'(-1234), DW'(9000 + i), 2'b11, 2'b01);

    // R7: bypass right (freeze set too), passthrough and cleared estimate
    cur_tag = "R7";
    for (int i = 0; i < 20; i++) drive(DW'(777), DW'(-8388608 + i), 2'b01, 2'b10);
    drive(DW'(777), DW'(4242), 2'b11, 2'b00);  // re-enabled: estimate starts at zero
    for (int i = 0; i < 20; i++) drive(DW'(i * 5), DW'(4242), 2'b11, 2'b00);

    // R8: drive opposite rails for many time constants
    cur_tag = "R8";
    for (int i = 0; i < 20000; i++) drive(DW'(MAXV), DW'(MINV), 2'b11, 2'b00);
    for (int i = 0; i < 10; i++) drive(DW'(MINV), DW'(100), 2'b11, 2'b11);
    for (int i = 0; i < 10; i++) drive(DW'(0), DW'(MAXV), 2'b11, 2'b11);
    for (int i = 0; i < 10; i++) drive(DW'(MINV), DW'(MAXV), 2'b11, 2'b11);

    // R9: same frozen estimates, small inputs, no clipping
    cur_tag = "R9";
    for (int i = 0; i < 20; i++) drive(DW'(i * 1000), DW'(-i * 1000), 2'b11, 2'b11);
    drive(DW'(MAXV), DW'(MINV), 2'b11, 2'b11);

    idle(4);
    check_flag("R2 queue drained", (sb.size() == 0), 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule